// File: doc/BRIEF.md
# ADC Sequence Status Flag Controller

This block holds the status side of a multi-channel analog-to-digital converter sequencer. It tracks whether a conversion sequence is running. A sequence starts on a start-register write, or on a trigger edge in edge-trigger mode. It ends when the core reports completion, or when software writes a configuration register, which aborts it. The block also keeps two sticky error flags. The trigger-overrun flag records a trigger edge that arrives while a sequence is already running. The result-overwrite flag records a result write to a channel whose conversion-complete flag is still set.

Each error flag clears when software writes a 1 to its bit of the status register. Each flag also clears as a side effect of writes to other registers. A one-bit test register enables special channels. While that bit is set, the three-bit channel-select code is decoded into a selection of an internal reference input and no longer names an external pin.

Top module: `adc_seq_status`

## Requirements
- R1: After reset `seq_active`, `trig_ovr`, `res_ovw`, `spec_en` and `test_rdata` are all 0.
- R2: A `start_wr` pulse makes `seq_active` 1 on the next cycle. A `seq_done` pulse makes it 0. Any bit of `cfg_wr` makes it 0 (abort), and the abort wins over a start in the same cycle. With `edge_mode`=1, a `trig_edge` while idle also starts a sequence.
- R3: With `edge_mode`=1 and `seq_active`=1, a `trig_edge` pulse sets `trig_ovr` on the next cycle.
- R4: `trig_ovr` is never set by a `trig_edge` while `edge_mode`=0 or while `seq_active`=0.
- R5: The status register layout is `stat_rdata[1]` = trigger overrun and `stat_rdata[0]` = result overwrite. It shows the registered flags, and reading it has no side effect. A status write with bit 1 set clears `trig_ovr`. Bits written as 0 leave their flag unchanged.
- R6: A write to any configuration register (any bit of `cfg_wr`) clears `trig_ovr`.
- R7: A `start_wr` pulse clears both `trig_ovr` and `res_ovw`.
- R8: A `res_wr` pulse sets `res_ovw` on the next cycle when `ccf[res_ch]` is 1. It has no effect when that bit is 0.
- R9: A status write with bit 0 set clears `res_ovw`.
- R10: When a set event and a clear of the same flag occur in one cycle, the flag ends up 1.
- R11: A `test_wr` loads `test_wdata` into `spec_en`. `test_rdata` is {7'b0, `spec_en`}.
- R12: With `spec_en`=1, `sel_code` 3'b100 gives `spec_sel`=1 (high reference), 3'b101 gives 2 (low reference) and 3'b110 gives 3 (midpoint). Any other code gives `spec_sel`=0 and `spec_rsvd`=1. In every case `ext_valid`=0 and `ext_ch`=0.
- R13: With `spec_en`=0, `ext_ch`=`sel_code`, `ext_valid`=1, `spec_sel`=0 and `spec_rsvd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| edge_mode | input | 1 | Edge-trigger mode enabled |
| cfg_wr | input | 3 | Write strobes of the three configuration registers |
| start_wr | input | 1 | Start-register write strobe |
| stat_wr | input | 1 | Status-register write strobe |
| stat_wdata | input | 2 | Status write data (bit 1 overrun, bit 0 overwrite) |
| test_wr | input | 1 | Test-register write strobe |
| test_wdata | input | 1 | Special-channel enable write value |
| trig_edge | input | 1 | Detected active external trigger edge |
| seq_done | input | 1 | Conversion sequence finished |
| res_wr | input | 1 | Result register write by the core |
| res_ch | input | 3 | Channel of the result write |
| ccf | input | 8 | Per-channel conversion-complete flags |
| sel_code | input | 3 | Channel-select code |
| seq_active | output | 1 | Conversion sequence running |
| trig_ovr | output | 1 | Trigger-overrun flag |
| res_ovw | output | 1 | Result-overwrite flag |
| stat_rdata | output | 2 | Status read data |
| test_rdata | output | 8 | Test register read data |
| spec_en | output | 1 | Special channels enabled |
| spec_sel | output | 2 | Internal input: 0 none, 1 high ref, 2 low ref, 3 midpoint |
| spec_rsvd | output | 1 | Reserved special code selected |
| ext_ch | output | 3 | External channel number |
| ext_valid | output | 1 | `ext_ch` selects an external channel |

## Verification
The assertions check on every cycle that an overrun flag only rises after a qualifying edge, and that a set event always leaves its flag at 1. They also check that a start write with no set pending clears both flags, that a configuration write always leaves the sequencer idle, and that the decoder never selects an internal input while special channels are off. The bench scenarios cover the rest: that a zero write changes nothing, the exact code-to-reference mapping, pass-through of the code, the read-as-zero test bits, and the priority between start, done and abort.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;
    typedef enum logic [1:0] {
        SPC_NONE     = 2'd0,
        SPC_VREF_HI  = 2'd1,
        SPC_VREF_LO  = 2'd2,
        SPC_VREF_MID = 2'd3
    } spc_sel_e;

    localparam logic [2:0] CODE_HI  = 3'b100;
    localparam logic [2:0] CODE_LO  = 3'b101;
    localparam logic [2:0] CODE_MID = 3'b110;
endpackage

// File: rtl/seq_tracker.sv
module seq_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic start,
    input  logic done,
    input  logic edge_mode,
    input  logic trig_edge,
    output logic active
);
    typedef struct packed {
        logic active;
    } trk_s;

    trk_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (abort)
            st_d.active = 1'b0;
        else if (start)
            st_d.active = 1'b1;
        else if (st_q.active && done)
            st_d.active = 1'b0;
        else if (!st_q.active && edge_mode && trig_edge)
            st_d.active = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !active); // R2
    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |=> active); // R2
endmodule

// File: rtl/err_flags.sv
module err_flags #(
    parameter int NCH  = 8,
    parameter int NCFG = 3,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            edge_mode,
    input  logic            seq_active,
    input  logic            trig_edge,
    input  logic [NCFG-1:0] cfg_wr,
    input  logic            start_wr,
    input  logic            stat_wr,
    input  logic [1:0]      stat_wdata,
    input  logic            res_wr,
    input  logic [CH_W-1:0] res_ch,
    input  logic [NCH-1:0]  ccf,
    output logic            ovr,
    output logic            ovw
);
    localparam int OVR_BIT = 1;
    localparam int OVW_BIT = 0;

    typedef struct packed {
        logic ovr;
        logic ovw;
    } flg_s;

    flg_s f_d, f_q;
    logic ovr_set, ovr_clr, ovw_set, ovw_clr;

    always_comb begin
        ovr_set = edge_mode && seq_active && trig_edge;
        ovr_clr = (stat_wr && stat_wdata[OVR_BIT]) || (|cfg_wr) || start_wr;
        ovw_set = res_wr && ccf[res_ch];
        ovw_clr = (stat_wr && stat_wdata[OVW_BIT]) || start_wr;
        f_d     = f_q;
        f_d.ovr = ovr_set || (f_q.ovr && !ovr_clr);
        f_d.ovw = ovw_set || (f_q.ovw && !ovw_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign ovr = f_q.ovr;
    assign ovw = f_q.ovw;

    AST_OVR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !$past(ovr)) |-> $past(edge_mode && seq_active && trig_edge)); // R4
    AST_OVR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && seq_active && trig_edge) |=> ovr); // R10
    AST_OVW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_wr && ccf[res_ch]) |=> ovw); // R8
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !(res_wr && ccf[res_ch]) && !(edge_mode && seq_active && trig_edge))
        |=> (!ovr && !ovw)); // R7
endmodule

// File: rtl/spec_decode.sv
module spec_decode
    import adc_stat_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_wr,
    input  logic             test_wdata,
    input  logic [SEL_W-1:0] sel_code,
    output logic             spec_en,
    output logic [7:0]       test_rdata,
    output spc_sel_e         spc_sel,
    output logic             spc_rsvd,
    output logic [SEL_W-1:0] ext_ch,
    output logic             ext_valid
);
    typedef struct packed {
        logic en;
    } tst_s;

    tst_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (test_wr) t_d.en = test_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign spec_en    = t_q.en;
    assign test_rdata = {7'b0, t_q.en};

    always_comb begin
        spc_sel   = SPC_NONE;
        spc_rsvd  = 1'b0;
        ext_ch    = '0;
        ext_valid = 1'b0;
        if (t_q.en) begin
            case (sel_code[2:0])
                CODE_HI:  spc_sel = SPC_VREF_HI;
                CODE_LO:  spc_sel = SPC_VREF_LO;
                CODE_MID: spc_sel = SPC_VREF_MID;
                default:  spc_rsvd = 1'b1;
            endcase
        end else begin
            ext_ch    = sel_code;
            ext_valid = 1'b1;
        end
    end

    AST_OFF_NO_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
        !spec_en |-> (spc_sel == SPC_NONE && !spc_rsvd)); // R13
    AST_TEST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        test_wr |=> (spec_en == $past(test_wdata))); // R11
endmodule

// File: rtl/adc_seq_status.sv
module adc_seq_status
    import adc_stat_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int NCFG  = 3,
    parameter int SEL_W = 3,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_mode,
    input  logic [NCFG-1:0]  cfg_wr,
    input  logic             start_wr,
    input  logic             stat_wr,
    input  logic [1:0]       stat_wdata,
    input  logic             test_wr,
    input  logic             test_wdata,
    input  logic             trig_edge,
    input  logic             seq_done,
    input  logic             res_wr,
    input  logic [CH_W-1:0]  res_ch,
    input  logic [NCH-1:0]   ccf,
    input  logic [SEL_W-1:0] sel_code,
    output logic             seq_active,
    output logic             trig_ovr,
    output logic             res_ovw,
    output logic [1:0]       stat_rdata,
    output logic [7:0]       test_rdata,
    output logic             spec_en,
    output logic [1:0]       spec_sel,
    output logic             spec_rsvd,
    output logic [SEL_W-1:0] ext_ch,
    output logic             ext_valid
);
    spc_sel_e sel_int;

    seq_tracker u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (|cfg_wr),
        .start     (start_wr),
        .done      (seq_done),
        .edge_mode (edge_mode),
        .trig_edge (trig_edge),
        .active    (seq_active)
    );

    err_flags #(.NCH(NCH), .NCFG(NCFG)) u_flg (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_mode  (edge_mode),
        .seq_active (seq_active),
        .trig_edge  (trig_edge),
        .cfg_wr     (cfg_wr),
        .start_wr   (start_wr),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata),
        .res_wr     (res_wr),
        .res_ch     (res_ch),
        .ccf        (ccf),
        .ovr        (trig_ovr),
        .ovw        (res_ovw)
    );

    spec_decode #(.SEL_W(SEL_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_wr    (test_wr),
        .test_wdata (test_wdata),
        .sel_code   (sel_code),
        .spec_en    (spec_en),
        .test_rdata (test_rdata),
        .spc_sel    (sel_int),
        .spc_rsvd   (spec_rsvd),
        .ext_ch     (ext_ch),
        .ext_valid  (ext_valid)
    );

    assign spec_sel   = sel_int;
    assign stat_rdata = {trig_ovr, res_ovw};

    AST_CFG_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        ((|cfg_wr) && !(edge_mode && seq_active && trig_edge)) |=> !trig_ovr); // R6
endmodule

// File: tb/sim_adc_seq_status.sv
module sim_adc_seq_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       edge_mode = 0, start_wr = 0, stat_wr = 0, test_wr = 0, test_wdata = 0;
    logic       trig_edge = 0, seq_done = 0, res_wr = 0;
    logic [2:0] cfg_wr = 0, res_ch = 0, sel_code = 0;
    logic [1:0] stat_wdata = 0;
    logic [7:0] ccf = 0;
    logic       seq_active, trig_ovr, res_ovw, spec_en, spec_rsvd, ext_valid;
    logic [1:0] stat_rdata, spec_sel;
    logic [7:0] test_rdata;
    logic [2:0] ext_ch;

    int n_chk = 0, n_bad = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    adc_seq_status u0 (
        .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .cfg_wr(cfg_wr),
        .start_wr(start_wr), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .test_wr(test_wr), .test_wdata(test_wdata), .trig_edge(trig_edge),
        .seq_done(seq_done), .res_wr(res_wr), .res_ch(res_ch), .ccf(ccf),
        .sel_code(sel_code), .seq_active(seq_active), .trig_ovr(trig_ovr),
        .res_ovw(res_ovw), .stat_rdata(stat_rdata), .test_rdata(test_rdata),
        .spec_en(spec_en), .spec_sel(spec_sel), .spec_rsvd(spec_rsvd),
        .ext_ch(ext_ch), .ext_valid(ext_valid)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // drive at negedge, release all strobes at the following negedge
    task automatic clr_strobes();
        start_wr = 0; stat_wr = 0; stat_wdata = 0; test_wr = 0; trig_edge = 0;
        seq_done = 0; res_wr = 0; cfg_wr = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        clr_strobes();
    endtask

    task automatic t_reset();
        check("R1 seq_active", seq_active, 0);
        check("R1 trig_ovr", trig_ovr, 0);
        check("R1 res_ovw", res_ovw, 0);
        check("R1 spec_en", spec_en, 0);
        check("R1 test_rdata", test_rdata, 0);
    endtask

    task automatic t_seq();
        edge_mode = 0;
        start_wr = 1; tick();
        check("R2 start", seq_active, 1);
        seq_done = 1; tick();
        check("R2 done", seq_active, 0);
        start_wr = 1; tick();
        cfg_wr = 3'b010; tick();
        check("R2 abort", seq_active, 0);
        start_wr = 1; cfg_wr = 3'b001; tick();
        check("R2 abort beats start", seq_active, 0);
        edge_mode = 1; trig_edge = 1; tick();
        check("R2 edge start", seq_active, 1);
        seq_done = 1; tick();
        edge_mode = 0;
    endtask

    task automatic t_ovr_set();
        edge_mode = 1; start_wr = 1; tick();
        trig_edge = 1; tick();
        check("R3 overrun set", trig_ovr, 1);
        check("R5 stat_rdata", stat_rdata, 2'b10);
        tick();
        check("R5 read stable", trig_ovr, 1);
        stat_wr = 1; stat_wdata = 2'b01; tick();
        check("R5 zero write keeps", trig_ovr, 1);
        stat_wr = 1; stat_wdata = 2'b10; tick();
        check("R5 w1c", trig_ovr, 0);
        seq_done = 1; tick();
        edge_mode = 0;
    endtask

    task automatic t_ovr_guard();
        edge_mode = 0; start_wr = 1; tick();
        trig_edge = 1; tick();
        check("R4 no edge mode", trig_ovr, 0);
        seq_done = 1; tick();
        edge_mode = 1; trig_edge = 1; tick();
        check("R4 idle trigger", trig_ovr, 0);
        seq_done = 1; tick();
        edge_mode = 0;
    endtask

    task automatic t_cfg_clear();
        edge_mode = 1; start_wr = 1; tick();
        trig_edge = 1; tick();
        cfg_wr = 3'b100; tick();
        check("R6 cfg clears", trig_ovr, 0);
        check("R6 cfg aborts", seq_active, 0);
        edge_mode = 0;
    endtask

    task automatic t_ovw();
        ccf = 8'b0010_0000;
        res_wr = 1; res_ch = 3'd4; tick();
        check("R8 ccf clear no set", res_ovw, 0);
        res_wr = 1; res_ch = 3'd5; tick();
        check("R8 overwrite set", res_ovw, 1);
        stat_wr = 1; stat_wdata = 2'b10; tick();
        check("R9 zero write keeps", res_ovw, 1);
        stat_wr = 1; stat_wdata = 2'b01; tick();
        check("R9 w1c", res_ovw, 0);
    endtask

    task automatic t_start_clear();
        ccf = 8'b0000_0001;
        edge_mode = 1; start_wr = 1; tick();
        trig_edge = 1; res_wr = 1; res_ch = 3'd0; tick();
        check("R7 pre ovr", trig_ovr, 1);
        check("R7 pre ovw", res_ovw, 1);
        start_wr = 1; tick();
        check("R7 ovr cleared", trig_ovr, 0);
        check("R7 ovw cleared", res_ovw, 0);
        seq_done = 1; tick();
        edge_mode = 0; ccf = 0;
    endtask

    task automatic t_set_wins();
        ccf = 8'b1000_0000;
        edge_mode = 1; start_wr = 1; tick();
        trig_edge = 1; stat_wr = 1; stat_wdata = 2'b11; res_wr = 1; res_ch = 3'd7; tick();
        check("R10 ovr set wins", trig_ovr, 1);
        check("R10 ovw set wins", res_ovw, 1);
        trig_edge = 1; cfg_wr = 3'b001; tick();
        check("R10 ovr beats cfg", trig_ovr, 1);
        stat_wr = 1; stat_wdata = 2'b11; tick();
        edge_mode = 0; ccf = 0;
    endtask

    task automatic t_test_reg();
        test_wr = 1; test_wdata = 1; tick();
        check("R11 enable", spec_en, 1);
        check("R11 readback", test_rdata, 8'h01);
        test_wr = 1; test_wdata = 0; tick();
        check("R11 disable", test_rdata, 8'h00);
    endtask

    task automatic t_decode();
        test_wr = 1; test_wdata = 1; tick();
        for (int c = 0; c < 8; c++) begin
            logic [1:0] es;
            sel_code = c[2:0];
            #1;
            es = (c == 4) ? 2'd1 : (c == 5) ? 2'd2 : (c == 6) ? 2'd3 : 2'd0;
            check("R12 spec_sel", spec_sel, es);
            check("R12 reserved", spec_rsvd, (es == 2'd0));
            check("R12 ext off", {ext_valid, ext_ch}, 0);
        end
        test_wr = 1; test_wdata = 0; tick();
        for (int c = 0; c < 8; c++) begin
            sel_code = c[2:0];
            #1;
            check("R13 pass", {ext_valid, ext_ch}, {1'b1, c[2:0]});
            check("R13 no special", {spec_rsvd, spec_sel}, 0);
        end
    endtask

    initial begin
        #100000;
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_seq();
        t_ovr_set();
        t_ovr_guard();
        t_cfg_clear();
        t_ovw();
        t_start_clear();
        t_set_wins();
        t_test_reg();
        t_decode();
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule